// File: doc/BRIEF.md
# Read-Merge-Write Front End for Unaligned Stores

This block sits between a requester and a memory that can only write whole words. The memory has no byte enables. The requester may write one byte, a halfword or a word at any byte address. The block puts the new bytes into the one or two memory words they touch. For each such word it reads the old value, clears the lanes being written and ORs in the new bytes, then writes the result back.

Reads and aligned full-word writes go straight through to the memory in the cycle they are offered. A partial or misaligned write is taken in and then runs as a fixed sequence. While that sequence runs, `req_ready` is low, so the requester, and any read it offers, waits.

The controller is one state machine with six states:

- IDLE: passes reads and full writes through, and accepts a partial write.
- RD1: reads the first word.
- WR1: merges and writes the first word.
- RD2: reads the next word up.
- WR2: merges and writes that word.
- DONE: spends one quiet cycle before the machine returns to IDLE.

The transitions are:

- IDLE→RD1 when a partial write is accepted.
- RD1→WR1 always.
- WR1→RD2 when the write reaches into the second word.
- WR1→DONE otherwise.
- RD2→WR2 always.
- WR2→DONE always.
- DONE→IDLE always.

Top module: `rmw_wr_merger`

## Requirements
- R1: A write whose size code is word (2) at a byte offset of 0 produces exactly one memory write (`mem_we`=1) to word `req_addr>>2`, with no memory read. It is accepted in the cycle it is offered, and `req_ready` stays high afterwards.
- R2: A read accepted in IDLE issues one memory read of word `req_addr>>2`. Exactly one cycle later `rsp_valid` is 1 and `rsp_rdata` carries that word. `rsp_valid` is 0 in every other cycle.
- R3: A partial write that stays inside one word performs, in order, a read of that word and then a write of that word. `req_ready` is low for exactly 3 cycles after acceptance (RD1, WR1, DONE).
- R4: A write that crosses a word boundary performs four memory accesses in this order: read word w, write word w, read word w+1, write word w+1. The address w+1 wraps modulo the number of words. `req_ready` is low for exactly 5 cycles after acceptance.
- R5: Merging is little-endian. Byte k of `req_wdata` goes to byte address `req_addr+k`. All other bytes of the affected words keep their old values. Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes, and code 3 is treated as 4 bytes.
- R6: While a merge sequence runs, `req_ready` is 0, so no request of any kind is accepted. A read offered during the sequence is accepted only once the machine is back in IDLE, and it returns the merged data.
- R7: After reset the block is in IDLE: `req_ready`=1, `rsp_valid`=0, and `mem_en`=0 while no request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code (0 byte, 1 half, 2/3 word) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data, least significant byte first |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_rdata | input | DATA_W | Memory read word, one cycle after the read |

## Verification
The hardest cases to reach are a boundary-crossing write at the top word, where the second address wraps to word 0, and a read that arrives while a merge sequence is still running. The bench sweeps every size and offset at the lowest, a middle and the top word. After each write it reads back the neighbouring words. For the overlap case it switches the held request from write to read on the cycle right after acceptance. It then counts the cycles that pass before the read is taken and checks the merged word the read returns.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_WR1,
        ST_RD2,
        ST_WR2,
        ST_DONE
    } rmw_state_t;

    localparam int SZ_W = 2;
endpackage

// File: rtl/rmw_lane_gen.sv
module rmw_lane_gen #(
    parameter int DATA_W = 32
) (
    input  logic [$clog2(DATA_W/8)-1:0]  off,
    input  logic [rmw_pkg::SZ_W-1:0]     size,
    input  logic [DATA_W-1:0]            wdata,
    output logic [2*(DATA_W/8)-1:0]      mask2,
    output logic [2*DATA_W-1:0]          data2,
    output logic                         full_word
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [rmw_pkg::SZ_W-1:0] eff;
    logic [OFF_W:0]           nb;
    logic [LANES-1:0]         base;
    logic [DATA_W-1:0]        dmask;

    assign eff = (32'(size) > OFF_W) ? rmw_pkg::SZ_W'(OFF_W) : size;
    assign nb  = (OFF_W+1)'(1) << eff;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign base[i]         = ((OFF_W+1)'(i) < nb);
        assign dmask[i*8 +: 8] = {8{base[i]}};
    end

    assign mask2     = {LANES'(0), base} << off;
    assign data2     = {DATA_W'(0), wdata & dmask} << {off, 3'b000};
    assign full_word = (eff == rmw_pkg::SZ_W'(OFF_W)) && (off == '0);
endmodule

// File: rtl/rmw_merge.sv
module rmw_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   old_word,
    input  logic [DATA_W-1:0]   new_word,
    input  logic [DATA_W/8-1:0] lane_mask,
    output logic [DATA_W-1:0]   merged
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] bitmask;

    for (genvar i = 0; i < LANES; i++) begin : g_bm
        assign bitmask[i*8 +: 8] = {8{lane_mask[i]}};
    end

    assign merged = (old_word & ~bitmask) | (new_word & bitmask);
endmodule

// File: rtl/rmw_wr_merger.sv
module rmw_wr_merger #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic                                 req_write,
    input  logic [rmw_pkg::SZ_W-1:0]             req_size,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic [DATA_W-1:0]                    req_wdata,
    output logic                                 rsp_valid,
    output logic [DATA_W-1:0]                    rsp_rdata,
    output logic                                 mem_en,
    output logic                                 mem_we,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0]   mem_addr,
    output logic [DATA_W-1:0]                    mem_wdata,
    input  logic [DATA_W-1:0]                    mem_rdata
);
    import rmw_pkg::*;

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int WA_W  = ADDR_W - OFF_W;

    rmw_state_t state, nstate;

    logic [2*LANES-1:0]  in_mask;
    logic [2*DATA_W-1:0] in_data;
    logic                in_full;
    logic [WA_W-1:0]     cap_wa;
    logic [2*LANES-1:0]  cap_mask;
    logic [2*DATA_W-1:0] cap_data;
    logic                sel_hi;
    logic                straddle;
    logic                accept_part;
    logic [LANES-1:0]    cur_mask;
    logic [DATA_W-1:0]   cur_data;
    logic [DATA_W-1:0]   merged;

    rmw_lane_gen #(.DATA_W(DATA_W)) u_lane (
        .off       (req_addr[OFF_W-1:0]),
        .size      (req_size),
        .wdata     (req_wdata),
        .mask2     (in_mask),
        .data2     (in_data),
        .full_word (in_full)
    );

    assign sel_hi   = (state == ST_WR2);
    assign cur_mask = sel_hi ? cap_mask[2*LANES-1:LANES] : cap_mask[LANES-1:0];
    assign cur_data = sel_hi ? cap_data[2*DATA_W-1:DATA_W] : cap_data[DATA_W-1:0];
    assign straddle = |cap_mask[2*LANES-1:LANES];

    rmw_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word  (mem_rdata),
        .new_word  (cur_data),
        .lane_mask (cur_mask),
        .merged    (merged)
    );

    assign accept_part = (state == ST_IDLE) && req_valid && req_write && !in_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // captured request and read response flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_wa    <= '0;
            cap_mask  <= '0;
            cap_data  <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= (state == ST_IDLE) && req_valid && !req_write;
            if (accept_part) begin
                cap_wa   <= req_addr[ADDR_W-1:OFF_W];
                cap_mask <= in_mask;
                cap_data <= in_data;
            end
        end
    end

    assign rsp_rdata = mem_rdata;

    // next state
    always_comb begin
        nstate = ST_IDLE;
        unique case (state)
            ST_IDLE: nstate = accept_part ? ST_RD1 : ST_IDLE;
            ST_RD1:  nstate = ST_WR1;
            ST_WR1:  nstate = straddle ? ST_RD2 : ST_DONE;
            ST_RD2:  nstate = ST_WR2;
            ST_WR2:  nstate = ST_DONE;
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cap_wa;
        mem_wdata = merged;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                mem_addr  = req_addr[ADDR_W-1:OFF_W];
                mem_wdata = req_wdata;
                if (req_valid && (!req_write || in_full)) begin
                    mem_en = 1'b1;
                    mem_we = req_write;
                end
            end
            ST_RD1: mem_en = 1'b1;
            ST_WR1: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            ST_RD2: begin
                mem_en   = 1'b1;
                mem_addr = cap_wa + WA_W'(1);
            end
            ST_WR2: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = cap_wa + WA_W'(1);
            end
            ST_DONE: ;
            default: ;
        endcase
    end

    // R1: a full aligned write leaves the machine in IDLE
    a_r1_full_no_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid && req_write && in_full) |=> (state == ST_IDLE));

    // R2: a read response only follows a cycle spent in IDLE
    a_r2_rsp_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(state) == ST_IDLE && state == ST_IDLE));

    // R3: the first read is always followed by the first write
    a_r3_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD1) |=> (state == ST_WR1 && mem_en && mem_we));

    // R4: the second read is followed by the second write
    a_r4_rd2_then_wr2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD2) |=> (state == ST_WR2 && mem_we));

    // R4: the second word sits one above the first
    a_r4_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR2) |-> (mem_addr == $past(mem_addr, 3) + WA_W'(1)));

    // R6: an accepted partial write blocks the next cycle
    a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        accept_part |=> !req_ready);

    // R5: lanes not written keep the old byte
    for (genvar g = 0; g < LANES; g++) begin : g_keep
        a_r5_keep_lane: assert property (@(posedge clk) disable iff (!rst_n)
            ((state == ST_WR1 || state == ST_WR2) && !cur_mask[g])
            |-> (mem_wdata[g*8 +: 8] == mem_rdata[g*8 +: 8]));
    end
endmodule

// File: tb/rmw_wr_merger_tb_top.sv
module rmw_wr_merger_tb_top;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int NW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [1:0]  req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic        rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic        mem_en, mem_we;
    logic [3:0]  mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    rmw_wr_merger #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [NW];
    logic [7:0]  refb [4*NW];
    logic [4:0]  lg [64];
    int          lg_n = 0;

    // memory model without byte enables, plus an access log {we, addr}
    always @(posedge clk) begin
        if (mem_en) begin
            lg[lg_n % 64] <= {mem_we, mem_addr};
            lg_n <= lg_n + 1;
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata     <= mem[mem_addr];
        end
    end

    logic rd_acc_q = 1'b0;
    int   spurious = 0;
    always @(posedge clk) rd_acc_q <= rst_n && req_valid && req_ready && !req_write;
    always @(negedge clk) if (rst_n && (rsp_valid !== rd_acc_q)) spurious++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_word(input int w);
        return {refb[4*w+3], refb[4*w+2], refb[4*w+1], refb[4*w]};
    endfunction

    task automatic do_read(input int w, output logic [31:0] d, output int waits);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(4*w); req_size = 2'd2;
        waits = 0;
        while (!req_ready) begin waits++; @(negedge clk); end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 rsp_valid after read", 32'(rsp_valid), 32'd1);
        d = rsp_rdata;
    endtask

    task automatic do_write(input int w, input int off, input int sz, input logic [31:0] data);
        int a, nb, base, stalls, n, w1, expn;
        logic full, strad;
        logic [31:0] rd;
        int dummy;
        a  = 4*w + off;
        nb = (sz >= 2) ? 4 : (1 << sz);
        full  = (nb == 4) && (off == 0);
        strad = (off + nb) > 4;
        w1 = (w + 1) % NW;
        @(negedge clk);
        base = lg_n;
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a);
        req_size = 2'(sz); req_wdata = data;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        stalls = 0;
        while (!req_ready && stalls < 50) begin stalls++; @(negedge clk); end
        for (int k = 0; k < nb; k++) refb[(a + k) % (4*NW)] = data[8*k +: 8];
        n = lg_n - base;
        if (full) begin
            chk("R1 stall cycles", 32'(stalls), 32'd0);
            chk("R1 access count", 32'(n), 32'd1);
            chk("R1 access write", 32'(lg[base % 64]), {27'd0, 1'b1, 4'(w)});
        end else if (!strad) begin
            chk("R3 stall cycles", 32'(stalls), 32'd3);
            chk("R3 access count", 32'(n), 32'd2);
            chk("R3 first read",   32'(lg[base % 64]),       {27'd0, 1'b0, 4'(w)});
            chk("R3 then write",   32'(lg[(base+1) % 64]),   {27'd0, 1'b1, 4'(w)});
        end else begin
            chk("R4 stall cycles", 32'(stalls), 32'd5);
            chk("R4 access count", 32'(n), 32'd4);
            chk("R4 read w",   32'(lg[base % 64]),     {27'd0, 1'b0, 4'(w)});
            chk("R4 write w",  32'(lg[(base+1) % 64]), {27'd0, 1'b1, 4'(w)});
            chk("R4 read w1",  32'(lg[(base+2) % 64]), {27'd0, 1'b0, 4'(w1)});
            chk("R4 write w1", 32'(lg[(base+3) % 64]), {27'd0, 1'b1, 4'(w1)});
        end
        expn = 0;
        for (int j = -1; j <= 2; j++) begin
            int ww;
            ww = (w + j + NW) % NW;
            do_read(ww, rd, dummy);
            chk("R5 merged readback", rd, ref_word(ww));
            expn++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R6 watchdog actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int waits, cnt;
        int wsel [3];
        wsel[0] = 0; wsel[1] = 6; wsel[2] = NW - 1;
        for (int i = 0; i < NW; i++) begin
            mem[i] = (i * 32'h01010101) ^ 32'hC3A50F00 ^ 32'(i);
            for (int b = 0; b < 4; b++) refb[4*i+b] = mem[i][8*b +: 8];
        end
        repeat (3) @(negedge clk);
        chk("R7 ready in reset", 32'(req_ready), 32'd1);
        chk("R7 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        chk("R7 mem_en in reset", 32'(mem_en), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 ready after reset", 32'(req_ready), 32'd1);
        chk("R7 mem_en idle", 32'(mem_en), 32'd0);

        cnt = 0;
        for (int wi = 0; wi < 3; wi++)
            for (int sz = 0; sz < 3; sz++)
                for (int off = 0; off < 4; off++) begin
                    cnt++;
                    do_write(wsel[wi], off, sz, 32'hA5000000 ^ (32'(cnt) * 32'h01030507));
                end

        // size code 3 is a word
        do_write(3, 0, 3, 32'h1234ABCD);
        do_write(9, 2, 3, 32'hFEDC0123);

        // R6: read offered right after a straddling write is accepted
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(4*10 + 3);
        req_size = 2'd2; req_wdata = 32'h89ABCDEF;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 4; k++) refb[4*10 + 3 + k] = req_wdata[8*k +: 8];
        req_write = 1'b0; req_addr = AW'(4*11);
        waits = 0;
        while (!req_ready && waits < 50) begin waits++; @(negedge clk); end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 read held off cycles", 32'(waits), 32'd5);
        chk("R6 read sees merged data", rsp_rdata, ref_word(11));

        for (int i = 0; i < NW; i++) begin
            do_read(i, rd, waits);
            chk("R5 final memory image", rd, ref_word(i));
        end
        repeat (2) @(negedge clk);
        chk("R2 no spurious rsp_valid", 32'(spurious), 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule